// File: doc/BRIEF.md
# Auxiliary Baud Tick Generator

This block is a standalone reload timer that paces two serial ports. An 8-bit counter starts at a programmed reload value, counts up once per prescaled step and, when it passes its all-ones state, produces an overflow and restarts from the reload value. Each port turns that overflow stream into its 16x oversampling tick. A port can use the overflows at full rate or at half rate, and it can route them separately to its transmitter and to its receiver.

Software programs two byte-wide registers through a simple write strobe: the reload value and a control byte. A core clock-mode input (`x2_mode`) sets the base step rate. When it is high, the base rate is one step per clock. When it is low, the base rate is one step every two clocks. A slow setting adds a further divide-by-6, which brings the standard mode down to the machine-cycle rate. Together these give the closed-form rate tick16 = 2^dbl x 2^x2 x Fclk / (2 x 2 x 6^(1-fast) x (256 - reload)), and the baud rate is that value divided by 16.

Top module: `aux_baud_gen`

## Requirements
- R1: After a synchronous active-low reset, the reload register and the control byte both read 00h and all four tick outputs are 0.
- R2: While the run bit (control bit 0) is 0, the counter holds the reload value, the prescaler and the half-rate dividers are cleared, and no tick output is asserted one cycle later.
- R3: While running, an overflow occurs once every (256 - reload) counter steps. The counter restarts from the reload value on the same edge, so no step is lost. Each tick output is registered and rises in the cycle after the edge that overflowed.
- R4: The fast bit (control bit 1) removes the divide-by-6 prescaler when it is 1 and inserts it when it is 0.
- R5: When `x2_mode` is 1, the counter steps at one per clock before the prescaler. When `x2_mode` is 0, it steps at one per two clocks. A run that starts at edge E0 with L clocks per step first overflows at edge E0 + L x (256 - reload).
- R6: For port p, control bit 2+p routes ticks to `tx_tick[p]` and control bit 4+p routes ticks to `rx_tick[p]`. A cleared bit keeps that output at 0, and each bit acts independently of the others.
- R7: For port p, control bit 6+p set to 1 issues a tick on every overflow. Set to 0, it issues a tick on every second overflow, starting with the second overflow after run begins, and never on two consecutive cycles.
- R8: A reload value written while the counter runs does not disturb the current period. It takes effect at the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x2_mode | input | 1 | Core clock mode: 1 gives one base step per clock, 0 gives one per two clocks |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = reload, 1 = control |
| wr_data | input | 8 | Write data |
| tx_tick | output | 2 | Per-port transmit 16x tick |
| rx_tick | output | 2 | Per-port receive 16x tick |

## Verification
Two events can land on the same edge: a reload write and an overflow that consumes the reload value, and also an overflow and the half-rate toggle of a port whose double bit is clear. The bench provokes the first by rewriting the reload register at arbitrary points of a short running period. It provokes the second by running the shortest period (reload FFh, no prescale) with one port doubled and the other not. A behavioural model counts down the clocks left to the next overflow. It is compared with the four tick outputs on every cycle. Fixed-length windows also count ticks against the closed-form period.

// File: rtl/abrg_pkg.sv
// Shared types for the auxiliary baud tick generator.
// Assumes exactly two serial ports; the control byte layout is fixed.
package abrg_pkg;
    localparam int PORTS = 2;

    // Register selector used on the write port.
    typedef enum logic {
        REG_RELOAD = 1'b0,
        REG_CTRL   = 1'b1
    } reg_sel_e;

    // Control byte: bit 0 run, bit 1 fast, bits 3:2 tx route,
    // bits 5:4 rx route, bits 7:6 per-port full-rate (double).
    typedef struct packed {
        logic [PORTS-1:0] dbl;
        logic [PORTS-1:0] rx_sel;
        logic [PORTS-1:0] tx_sel;
        logic             fast;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/abrg_regs.sv
// Register file: holds the reload value and the control byte.
// Assumes one write per cycle; writes land on the clock edge.
module abrg_regs
    import abrg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload,
    output ctrl_t            ctrl
);
    // Capture register writes; both registers clear on reset (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
            ctrl   <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == REG_CTRL) ctrl <= ctrl_t'(wr_data[7:0]);
            else                                reload <= wr_data;
        end
    end

    // R1: reset leaves the generator stopped.
    p_reset_stop_r1: assert property (@(posedge clk) !rst_n |=> !ctrl.run);
endmodule

// File: rtl/abrg_prescale.sv
// Step prescaler: issues one step every L clocks, where
// L = (x2 ? 1 : 2) * (fast ? 1 : SLOW_DIV). It is cleared while stopped.
// Assumes x2 and fast are changed only while stopped; a count that is
// left beyond a new limit simply steps on the next clock.
module abrg_prescale #(
    parameter int SLOW_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic x2,
    output logic step
);
    localparam int MAX_L = 2 * SLOW_DIV;
    localparam int PRE_W = $clog2(MAX_L);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit_m1;
    int               lim;

    // Derive the terminal count from the clock mode and speed bit (R4, R5).
    always_comb begin
        lim      = (x2 ? 1 : 2) * (fast ? 1 : SLOW_DIV);
        limit_m1 = PRE_W'(lim - 1);
        step     = run && (pre_cnt >= limit_m1);
    end

    // Advance the prescale count, clearing it when stopped or on a step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_cnt <= '0;
        else if (step)      pre_cnt <= '0;
        else                pre_cnt <= pre_cnt + 1'b1;
    end

    // R2: no step is issued while stopped.
    p_no_step_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !step);
    // R4: in fast mode with x2 set, a running prescaler steps every clock.
    p_fast_x2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fast && x2) |-> step);
endmodule

// File: rtl/abrg_counter.sv
// Reload counter: counts up one per step from the reload value and
// flags an overflow when it steps out of the all-ones state.
// Assumes the reload value is sampled at the overflow edge (R8).
module abrg_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt;
    logic             at_top;

    // Detect the step that leaves the all-ones state.
    always_comb begin
        at_top = (cnt == {CNT_W{1'b1}});
        ovf    = run && step && at_top;
    end

    // Hold at reload when stopped; count or reload on each step (R2, R3).
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= reload;
        else if (step) begin
            if (at_top)      cnt <= reload;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R3: an overflow restarts from the reload value on the same edge.
    p_reload_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == $past(reload)));
    // R3: a non-overflowing step advances by exactly one.
    p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !at_top) |=> (cnt == $past(cnt) + 1'b1));
    // R2: a stopped counter tracks the reload register.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == $past(reload)));
endmodule

// File: rtl/abrg_port.sv
// Per-port tick shaper: optional divide-by-2 of the overflow stream,
// then registered routing to the port's transmitter and receiver.
// Assumes the half-rate phase restarts whenever the generator stops.
module abrg_port (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ovf,
    input  logic dbl,
    input  logic tx_sel,
    input  logic rx_sel,
    output logic tx_tick,
    output logic rx_tick
);
    logic half;
    logic tick16;

    // A tick passes on every overflow when doubled, else every second one.
    always_comb tick16 = ovf && (dbl || half);

    // Toggle the half-rate phase on overflows of an undoubled port (R7).
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   half <= 1'b0;
        else if (ovf && !dbl) half <= ~half;
    end

    // Register the routed ticks (R3, R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
        end else begin
            tx_tick <= tick16 && tx_sel;
            rx_tick <= tick16 && rx_sel;
        end
    end

    // R6: unrouted outputs stay low.
    p_tx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_sel |=> !tx_tick);
    p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sel |=> !rx_tick);
    // R7: an undoubled port never ticks on two consecutive cycles.
    p_half_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && !dbl) ##1 !dbl |-> !tick16);
    // R2: a stopped generator raises no tick.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!tx_tick && !rx_tick));
endmodule

// File: rtl/aux_baud_gen.sv
// Auxiliary baud tick generator top: register file, prescaler,
// shared reload counter and one tick shaper per serial port.
// Assumes the clock-mode input and speed bit change only while stopped.
module aux_baud_gen
    import abrg_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SLOW_DIV = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x2_mode,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [PORTS-1:0] tx_tick,
    output logic [PORTS-1:0] rx_tick
);
    logic [CNT_W-1:0] reload;
    ctrl_t            ctrl;
    logic             step;
    logic             ovf;

    abrg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .reload  (reload),
        .ctrl    (ctrl)
    );

    abrg_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.run),
        .fast  (ctrl.fast),
        .x2    (x2_mode),
        .step  (step)
    );

    abrg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl.run),
        .step   (step),
        .reload (reload),
        .ovf    (ovf)
    );

    // One tick shaper per serial port.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        abrg_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (ctrl.run),
            .ovf     (ovf),
            .dbl     (ctrl.dbl[p]),
            .tx_sel  (ctrl.tx_sel[p]),
            .rx_sel  (ctrl.rx_sel[p]),
            .tx_tick (tx_tick[p]),
            .rx_tick (rx_tick[p])
        );
    end

    // R2: an overflow only happens while running.
    p_ovf_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ctrl.run);
    // R1: reset clears every tick output.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_tick == '0 && rx_tick == '0));
endmodule

// File: tb/aux_baud_gen_test.sv
module aux_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x2_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] tx_tick;
    logic [1:0] rx_tick;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit chk_on = 1'b0;
    bit done = 1'b0;

    aux_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: clocks remaining to the next overflow.
    int         m_reload = 0;
    logic [7:0] m_ctrl = 8'h00;
    int         m_rem = 0;
    bit         m_half[2];
    logic [3:0] exp_out = 4'h0;

    function automatic int clocks_per_step(input logic [7:0] c, input logic x2);
        return (x2 ? 1 : 2) * (c[1] ? 1 : 6);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reload = 0; m_ctrl = 8'h00; m_half[0] = 0; m_half[1] = 0;
            exp_out = 4'h0;
        end else begin
            bit ovf;
            bit old_run;
            ovf = 0;
            old_run = m_ctrl[0];
            if (old_run) begin
                m_rem--;
                if (m_rem == 0) begin
                    ovf = 1;
                    m_rem = clocks_per_step(m_ctrl, x2_mode) * (256 - m_reload);
                end
            end
            for (int p = 0; p < 2; p++) begin
                bit t;
                t = 0;
                if (ovf) begin
                    if (m_ctrl[6+p]) t = 1;
                    else begin
                        if (m_half[p]) t = 1;
                        m_half[p] = !m_half[p];
                    end
                end
                if (!old_run) m_half[p] = 0;
                exp_out[p]   = t & m_ctrl[2+p];
                exp_out[2+p] = t & m_ctrl[4+p];
            end
            if (wr_en) begin
                if (wr_sel) m_ctrl = wr_data;
                else        m_reload = int'(wr_data);
            end
            if (!old_run) m_rem = clocks_per_step(m_ctrl, x2_mode) * (256 - m_reload);
        end
    end

    // Cycle-by-cycle comparison, plus tick counters for windows.
    int  tcnt[4];
    bit  cnt_on = 1'b0;
    always @(negedge clk) begin
        if (chk_on && !done)
            check({rx_tick, tx_tick} === exp_out, cur_req,
                  int'({rx_tick, tx_tick}), int'(exp_out));
        if (cnt_on) begin
            tcnt[0] += int'(tx_tick[0]); tcnt[1] += int'(tx_tick[1]);
            tcnt[2] += int'(rx_tick[0]); tcnt[3] += int'(rx_tick[1]);
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(input int n);
        for (int i = 0; i < 4; i++) tcnt[i] = 0;
        cnt_on = 1'b1;
        repeat (n) @(negedge clk);
        cnt_on = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk_on = 1'b1;
        rst_n = 1'b1;
        // R1: reset state, no ticks at the ports
        @(negedge clk);
        check({rx_tick, tx_tick} == 4'h0, "R1", int'({rx_tick, tx_tick}), 0);

        // R3 / R5: fast, x2, reload F0, all routed and doubled: period 16
        cur_req = "R3";
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'hFF);
        idle(20);
        window(160);
        check(tcnt[0] == 10, "R3", tcnt[0], 10);
        check(tcnt[3] == 10, "R3", tcnt[3], 10);

        // R7: reload FF period 1; port 0 doubled, port 1 half rate
        cur_req = "R7";
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'h7F);
        idle(5);
        window(40);
        check(tcnt[0] == 40, "R7", tcnt[0], 40);
        check(tcnt[1] == 20, "R7", tcnt[1], 20);
        check(tcnt[3] == 20, "R7", tcnt[3], 20);

        // R4 / R5 / R6: x2=0, slow (12 clocks per step), reload FC: period 48
        cur_req = "R4";
        wr(1'b1, 8'h00);
        x2_mode = 1'b0;
        wr(1'b0, 8'hFC);
        wr(1'b1, 8'hE5);
        idle(60);
        window(480);
        check(tcnt[0] == 10, "R4", tcnt[0], 10);
        check(tcnt[3] == 10, "R5", tcnt[3], 10);
        check(tcnt[2] == 0,  "R6", tcnt[2], 0);
        check(tcnt[1] == 0,  "R6", tcnt[1], 0);

        // R5 / R7: x2=1, slow (6 per step), reload 00, half rate: period 3072
        cur_req = "R5";
        wr(1'b1, 8'h00);
        x2_mode = 1'b1;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h05);
        idle(3200);
        window(6144);
        check(tcnt[0] == 2, "R5", tcnt[0], 2);

        // R2: stopped with every route set: no ticks
        cur_req = "R2";
        wr(1'b1, 8'hFC);
        window(200);
        check(tcnt[0] + tcnt[1] + tcnt[2] + tcnt[3] == 0, "R2",
              tcnt[0] + tcnt[1] + tcnt[2] + tcnt[3], 0);

        // R8: reload rewritten while running, at several phases
        cur_req = "R8";
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'hFF);
        for (int k = 0; k < 12; k++) begin
            idle(7 + 3 * k);
            wr(1'b0, (k % 2 == 0) ? 8'hF8 : 8'hF3);
        end
        idle(100);
        // R8: after settling on F3 the period is 13
        window(130);
        check(tcnt[0] == 10, "R8", tcnt[0], 10);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule